// File: doc/BRIEF.md
# Mixing and Midscale Stuffing Output Selector

This block takes the 14-bit offset-binary stream that leaves a 2x interpolator and prepares the word for the DAC. Two mode inputs select one of four output patterns. Pass-through sends samples unchanged. Half-wave mixing negates every second sample about midscale, which moves the spectrum to the high-pass image. Stuffing follows each sample with a midscale word, which doubles the rate. Mixing and stuffing together give a quarter-wave mixed pattern.

The block runs on the DAC update clock. A clock enable `en_i` marks the 4x-rate ticks, and consecutive enabled ticks alternate between a data slot and a stuff slot. A new input sample is taken on every data-slot tick. On a stuff-slot tick the block emits midscale only when stuffing is active. The output register updates one clock after the enabled edge, and `dvld_o` pulses for that one cycle.

Top module: `mixstuff_top`

## Requirements
- R1: While `rst_ni` is low, `dout_o` is 0x2000 and `dvld_o` is 0. The first enabled tick after reset is a data slot, and the first mixed sample after reset is not inverted.
- R2: A clock with `en_i` low yields `dvld_o` = 0 on the next cycle. On such a clock `dout_o`, the slot and the mixing phase all hold.
- R3: With both mode inputs low, each data-slot tick gives `dout_o` = `din_i` with `dvld_o` = 1 one clock later. Stuff-slot ticks give `dvld_o` = 0, so valid comes at the 2x rate.
- R4: With `mix_i` high, data samples are alternately passed and negated. The first sample after `mix_i` is sampled high is passed. A data tick with `mix_i` low clears the phase back to pass.
- R5: Negation maps x to 0x4000 − x, so 0x2000 stays 0x2000 and 0x3FFF becomes 0x0001. The code 0x0000 maps to 0x3FFF.
- R6: With `stuff_i` high, each stuff-slot tick outputs 0x2000 with `dvld_o` = 1, so valid comes on every enabled tick.
- R7: With both mode inputs high, the output runs +x0, 0x2000, −x1, 0x2000 and then repeats.
- R8: The mode inputs are sampled only on data-slot ticks. A change during a stuff slot has no effect until the next data slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DAC update clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | 4x-rate tick enable |
| din_i | input | 14 | Offset-binary sample at the 2x rate |
| mix_i | input | 1 | Half-wave mixing select, active high |
| stuff_i | input | 1 | Midscale stuffing select, active high |
| dout_o | output | 14 | Offset-binary word to the DAC |
| dvld_o | output | 1 | Output word valid, one-cycle pulse |

## Verification
The hardest state to reach is a mode change in the middle of a stuffed pair. To get there, the stimulus changes the mode pins on the stuff-slot tick in both directions: from mixing-only to stuffing, and from stuffing to pass-through. The output then has to follow the mode that was latched at the preceding data slot. A second hard case is a reset applied while the mixing phase is inverted and the slot points at stuffing. That point is reached by feeding one mixed sample first, and the bench then checks that the next sample after release comes out non-inverted.

// File: rtl/mixstuff_pkg.sv
package mixstuff_pkg;
  typedef enum logic {SLOT_DATA = 1'b0, SLOT_STUFF = 1'b1} slot_e;
  typedef struct packed {
    logic stuff;
    logic mix;
  } mode_t;
endpackage

// File: rtl/mixstuff_ctrl.sv
module mixstuff_ctrl
  import mixstuff_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  mode_t mode_i,
  output slot_e slot_o,
  output mode_t mode_o,
  output logic  inv_o,
  output logic  data_tick_o,
  output logic  stuff_tick_o
);
  slot_e slot_q;
  mode_t mode_q;
  logic  phase_q;

  assign data_tick_o  = en_i && (slot_q == SLOT_DATA);
  assign stuff_tick_o = en_i && (slot_q == SLOT_STUFF) && mode_q.stuff;
  assign inv_o        = mode_i.mix && phase_q;
  assign slot_o       = slot_q;
  assign mode_o       = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= SLOT_DATA;
      mode_q  <= '0;
      phase_q <= 1'b0;
    end else if (en_i) begin
      slot_q <= (slot_q == SLOT_DATA) ? SLOT_STUFF : SLOT_DATA;
      if (slot_q == SLOT_DATA) begin
        mode_q  <= mode_i;
        // phase restarts at pass whenever mixing is off
        phase_q <= mode_i.mix ? ~phase_q : 1'b0;
      end
    end
  end

  a_r8_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_tick_o |=> $stable(mode_q));
  a_r4_phase_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_tick_o && !mode_i.mix) |=> !phase_q);
  a_r2_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(slot_q) && $stable(phase_q)));
endmodule

// File: rtl/mixstuff_negate.sv
module mixstuff_negate #(
  parameter int DW = 14
) (
  input  logic [DW-1:0] x_i,
  input  logic          inv_i,
  output logic [DW-1:0] y_o
);
  localparam logic [DW:0] FULL = (DW+1)'(1) << DW;
  logic [DW:0] diff;

  always_comb begin
    diff = FULL - {1'b0, x_i};
    if (!inv_i)       y_o = x_i;
    else if (diff[DW]) y_o = '1;  // bottom code saturates to top
    else              y_o = diff[DW-1:0];
  end
endmodule

// File: rtl/mixstuff_top.sv
module mixstuff_top
  import mixstuff_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] din_i,
  input  logic          mix_i,
  input  logic          stuff_i,
  output logic [DW-1:0] dout_o,
  output logic          dvld_o
);
  localparam logic [DW-1:0] MID  = DW'(1) << (DW-1);
  localparam logic [DW:0]   FULL = (DW+1)'(1) << DW;

  mode_t       mode_in;
  slot_e       slot;
  mode_t       mode_cur;
  logic        inv, data_tick, stuff_tick;
  logic [DW-1:0] mixed;

  assign mode_in = '{stuff: stuff_i, mix: mix_i};

  mixstuff_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .mode_i      (mode_in),
    .slot_o      (slot),
    .mode_o      (mode_cur),
    .inv_o       (inv),
    .data_tick_o (data_tick),
    .stuff_tick_o(stuff_tick)
  );

  mixstuff_negate #(.DW(DW)) u_neg (
    .x_i  (din_i),
    .inv_i(inv),
    .y_o  (mixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o <= MID;
      dvld_o <= 1'b0;
    end else begin
      dvld_o <= data_tick || stuff_tick;
      if (data_tick)       dout_o <= mixed;
      else if (stuff_tick) dout_o <= MID;
    end
  end

  a_r6_stuff_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && slot == SLOT_STUFF && mode_cur.stuff) |=> (dvld_o && dout_o == MID));
  a_r3_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && slot == SLOT_DATA && !mix_i) |=> (dvld_o && dout_o == $past(din_i)));
  a_r5_negate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_tick && inv) |=> ((dout_o == '1 && $past(din_i) == '0) ||
                            ({1'b0, dout_o} + {1'b0, $past(din_i)} == FULL)));
  a_r2_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!dvld_o && $stable(dout_o)));
endmodule

// File: tb/mixstuff_top_test.sv
module mixstuff_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [13:0] din = '0;
  logic        mix = 1'b0;
  logic        stuff = 1'b0;
  logic [13:0] dout;
  logic        dvld;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  mixstuff_top uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .din_i(din),
    .mix_i(mix), .stuff_i(stuff), .dout_o(dout), .dvld_o(dvld)
  );

  // {req[3:0], en, stuff, mix, din[13:0], exp_vld, exp_dout[13:0]}
  localparam int NV = 22;
  localparam logic [35:0] VEC [NV] = '{
    {4'd3, 3'b100, 14'h1234, 1'b1, 14'h1234},  // R3 pass
    {4'd3, 3'b100, 14'h0000, 1'b0, 14'h1234},  // R3 stuff slot, no valid
    {4'd4, 3'b101, 14'h1000, 1'b1, 14'h1000},  // R4 first mixed passes
    {4'd4, 3'b101, 14'h0000, 1'b0, 14'h1000},
    {4'd4, 3'b101, 14'h1000, 1'b1, 14'h3000},  // R4 second negated
    {4'd4, 3'b101, 14'h0000, 1'b0, 14'h3000},
    {4'd2, 3'b001, 14'h0555, 1'b0, 14'h3000},  // R2 no tick
    {4'd4, 3'b101, 14'h0000, 1'b1, 14'h0000},
    {4'd4, 3'b101, 14'h0000, 1'b0, 14'h0000},
    {4'd5, 3'b101, 14'h0000, 1'b1, 14'h3FFF},  // R5 bottom code saturates
    {4'd8, 3'b110, 14'h0000, 1'b0, 14'h3FFF},  // R8 stuff ignored mid-pair
    {4'd6, 3'b110, 14'h2ABC, 1'b1, 14'h2ABC},
    {4'd8, 3'b100, 14'h0000, 1'b1, 14'h2000},  // R8 latched stuff kept
    {4'd7, 3'b111, 14'h0800, 1'b1, 14'h0800},  // R7 +x0
    {4'd7, 3'b111, 14'h0000, 1'b1, 14'h2000},
    {4'd7, 3'b111, 14'h0800, 1'b1, 14'h3800},  // R7 -x1
    {4'd7, 3'b111, 14'h0000, 1'b1, 14'h2000},
    {4'd7, 3'b111, 14'h3FFF, 1'b1, 14'h3FFF},
    {4'd6, 3'b111, 14'h0000, 1'b1, 14'h2000},  // R6
    {4'd5, 3'b111, 14'h2000, 1'b1, 14'h2000},  // R5 midscale fixed point
    {4'd2, 3'b011, 14'h1111, 1'b0, 14'h2000},  // R2 hold in stuff slot
    {4'd6, 3'b111, 14'h0000, 1'b1, 14'h2000}
  };

  task automatic check(input int req, input logic ev, input logic [13:0] ed);
    n_chk++;
    if (dvld !== ev || dout !== ed) begin
      n_bad++;
      $display("FAIL R%0d: dvld=%0b dout=%h expected dvld=%0b dout=%h",
               req, dvld, dout, ev, ed);
    end
  endtask

  task automatic step(input logic e, input logic s, input logic m, input logic [13:0] d);
    en = e; stuff = s; mix = m; din = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, 14'h2000);  // R1 reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][31], VEC[i][30], VEC[i][29], VEC[i][28:15]);
      check(int'(VEC[i][35:32]), VEC[i][14], VEC[i][13:0]);
    end
    // R1: reset while phase inverted and slot at stuff
    step(1'b1, 1'b0, 1'b1, 14'h1000);
    check(4, 1'b1, 14'h1000);
    en = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 14'h2000);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b1, 14'h1000);
    check(1, 1'b1, 14'h1000);  // R1 data slot, non-inverted
    step(1'b1, 1'b0, 1'b1, 14'h0000);
    check(1, 1'b0, 14'h1000);
    step(1'b1, 1'b0, 1'b1, 14'h3FFF);
    check(5, 1'b1, 14'h0001);  // R5 top code
    step(1'b0, 1'b0, 1'b0, 14'h0000);
    check(2, 1'b0, 14'h0001);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule